// File: doc/BRIEF.md
# Debug Link Mode-Switch Sequence Generator

This block drives a two-wire serial debug link with the fixed framing sequences that move a debug port between its wire protocols and its low-power dormant state. The link has a clock line and a single data/mode-select line. A command code picks one of seven sequences. Each sequence is built from a short list of segments: runs of ones, runs of zeros, and stored bit patterns. The segments are played out one bit per link clock pulse.

A controller puts a command code on `cmd` and pulses `start` while `busy` is low. `busy` then stays high until the high phase of the final bit's clock pulse ends. For one cycle after that, `done` is high. Each bit occupies one link clock period. The clock is low for `HALF_CYC` system cycles and then high for `HALF_CYC` system cycles. The data line changes only while the clock is low, so a target that samples on the rising clock edge sees stable data.

Top module: `modesw_gen`

## Requirements
- R1: After reset and while idle, `busy`, `done`, `lnk_clk` and `lnk_dat` are all 0.
- R2: Command 0 (line reset) emits 56 ones, then 8 zeros, for 64 bits in total.
- R3: Command 1 (JTAG to SWD) emits 56 ones, the 16-bit value 0xE79E, 56 ones, then 8 zeros, for 136 bits in total.
- R4: Command 2 (SWD to JTAG) emits 56 ones, the 16-bit value 0xE73C, then 8 ones, for 80 bits in total.
- R5: Command 3 (SWD to dormant) emits 56 ones, then the 16-bit value 0xE3BC, for 72 bits in total.
- R6: Command 4 (dormant to SWD) emits 8 ones, the 128-bit selection alert, 4 zeros, the 8-bit value 0x1A, 68 ones, then 8 zeros, for 224 bits in total. The alert is the byte list 92 F3 09 62 95 2D 85 86 E9 AF DD E3 A2 0E BC 19, sent first byte first. Every multi-bit value in every sequence is sent least significant bit first.
- R7: Command 5 (JTAG to dormant) emits 9 ones, then the low 31 bits of 0x33BBBBBA, for 40 bits in total.
- R8: Command 6 (dormant to JTAG) emits 8 ones, the 128-bit selection alert, then 24 zeros, for 160 bits in total. The 24 zeros are 4 low bits, 12 activation bits and 8 idle bits.
- R9: Each bit is one link clock period, made of `HALF_CYC` cycles with `lnk_clk` low followed by `HALF_CYC` cycles with it high. `lnk_dat` does not change while `lnk_clk` is high.
- R10: `busy` rises in the cycle after an accepted start. It falls when the last bit's high phase ends. `done` is high for exactly the first cycle in which `busy` is low again.
- R11: A start received while `busy` is high is ignored, and the running sequence continues unchanged.
- R12: Command code 7 is not a sequence. A start carrying it is ignored, and no clock pulses appear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to begin the sequence selected by `cmd` |
| cmd | input | 3 | Sequence selector, codes 0 to 6 |
| busy | output | 1 | A sequence is being emitted |
| done | output | 1 | One-cycle pulse after the last bit |
| lnk_clk | output | 1 | Link clock |
| lnk_dat | output | 1 | Link data / mode-select line |

## Verification
The bench compares every sampled bit against an expected stream built from byte lists and run lengths. This catches a byte-order or bit-order error in the alert pattern, which would flip bits inside the 128-bit window, and an off-by-one run length, which would shift every later bit and change the total count. The bench pulses a foreign start in the middle of a long sequence to expose a design that restarts or switches pattern. It also sends command code 7 to expose a design that emits a stray clock. The bench measures the spacing between rising edges and the data stability during the high phase, which catches a divider that miscounts or data that moves on the wrong edge. It also checks the `done` pulse cycle, which catches a `busy` that drops one bit too early.

// File: rtl/modesw_pkg.sv
package modesw_pkg;

  typedef enum logic [1:0] {SEG_HIGH, SEG_LOW, SEG_PAT} seg_kind_e;
  typedef enum logic [2:0] {PAT_J2S, PAT_S2J, PAT_S2D, PAT_ALERT, PAT_ACT_SWD, PAT_J2D} pat_e;

  typedef struct packed {
    seg_kind_e  kind;
    logic [7:0] len;
    pat_e       pat;
  } seg_t;

  localparam int SEG_IDX_W = 3;
  localparam int BIT_IDX_W = 8;
  localparam int CNT_W     = 8;

  localparam logic [2:0] CMD_LINE_RST = 3'd0;
  localparam logic [2:0] CMD_J2S      = 3'd1;
  localparam logic [2:0] CMD_S2J      = 3'd2;
  localparam logic [2:0] CMD_S2D      = 3'd3;
  localparam logic [2:0] CMD_D2S      = 3'd4;
  localparam logic [2:0] CMD_J2D      = 3'd5;
  localparam logic [2:0] CMD_D2J      = 3'd6;

  // Stored patterns, bit 0 leaves the block first.
  localparam logic [15:0]  J2S_CODE   = 16'hE79E;
  localparam logic [15:0]  S2J_CODE   = 16'hE73C;
  localparam logic [15:0]  S2D_CODE   = 16'hE3BC;
  localparam logic [7:0]   ACT_SWD    = 8'h1A;
  localparam logic [31:0]  J2D_CODE   = 32'h33BBBBBA;
  localparam logic [127:0] ALERT_CODE = 128'h19BC0EA2E3DDAFE986852D956209F392;

  function automatic seg_t mk(seg_kind_e k, int n, pat_e p);
    seg_t s;
    s.kind = k;
    s.len  = 8'(n);
    s.pat  = p;
    return s;
  endfunction

  function automatic logic [SEG_IDX_W-1:0] seg_count(logic [2:0] c);
    case (c)
      CMD_LINE_RST: return 3'd2;
      CMD_J2S:      return 3'd4;
      CMD_S2J:      return 3'd3;
      CMD_S2D:      return 3'd2;
      CMD_D2S:      return 3'd6;
      CMD_J2D:      return 3'd2;
      CMD_D2J:      return 3'd3;
      default:      return 3'd0;
    endcase
  endfunction

  function automatic seg_t seg_at(logic [2:0] c, logic [SEG_IDX_W-1:0] i);
    seg_t s;
    s = mk(SEG_LOW, 1, PAT_J2S);
    case (c)
      CMD_LINE_RST: s = (i == 0) ? mk(SEG_HIGH, 56, PAT_J2S) : mk(SEG_LOW, 8, PAT_J2S);
      CMD_J2S: case (i)
        3'd0:    s = mk(SEG_HIGH, 56, PAT_J2S);
        3'd1:    s = mk(SEG_PAT, 16, PAT_J2S);
        3'd2:    s = mk(SEG_HIGH, 56, PAT_J2S);
        default: s = mk(SEG_LOW, 8, PAT_J2S);
      endcase
      CMD_S2J: case (i)
        3'd0:    s = mk(SEG_HIGH, 56, PAT_J2S);
        3'd1:    s = mk(SEG_PAT, 16, PAT_S2J);
        default: s = mk(SEG_HIGH, 8, PAT_J2S);
      endcase
      CMD_S2D: s = (i == 0) ? mk(SEG_HIGH, 56, PAT_J2S) : mk(SEG_PAT, 16, PAT_S2D);
      CMD_D2S: case (i)
        3'd0:    s = mk(SEG_HIGH, 8, PAT_J2S);
        3'd1:    s = mk(SEG_PAT, 128, PAT_ALERT);
        3'd2:    s = mk(SEG_LOW, 4, PAT_J2S);
        3'd3:    s = mk(SEG_PAT, 8, PAT_ACT_SWD);
        3'd4:    s = mk(SEG_HIGH, 68, PAT_J2S);
        default: s = mk(SEG_LOW, 8, PAT_J2S);
      endcase
      CMD_J2D: s = (i == 0) ? mk(SEG_HIGH, 9, PAT_J2S) : mk(SEG_PAT, 31, PAT_J2D);
      CMD_D2J: case (i)
        3'd0:    s = mk(SEG_HIGH, 8, PAT_J2S);
        3'd1:    s = mk(SEG_PAT, 128, PAT_ALERT);
        default: s = mk(SEG_LOW, 24, PAT_J2S);
      endcase
      default: s = mk(SEG_LOW, 1, PAT_J2S);
    endcase
    return s;
  endfunction

  // Total length per command, kept apart from the segment table.
  function automatic logic [CNT_W-1:0] seq_bits(logic [2:0] c);
    case (c)
      CMD_LINE_RST: return 8'd64;
      CMD_J2S:      return 8'd136;
      CMD_S2J:      return 8'd80;
      CMD_S2D:      return 8'd72;
      CMD_D2S:      return 8'd224;
      CMD_J2D:      return 8'd40;
      CMD_D2J:      return 8'd160;
      default:      return 8'd0;
    endcase
  endfunction

  function automatic logic cmd_ok(logic [2:0] c);
    return seg_count(c) != 0;
  endfunction

endpackage

// File: rtl/dsg_phase.sv
module dsg_phase #(
  parameter int HALF_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic half_end
);
  localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

  logic [CW-1:0] cnt;

  assign half_end = run && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (!run)     cnt <= '0;
    else if (half_end) cnt <= '0;
    else               cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/dsg_pattern.sv
module dsg_pattern
  import modesw_pkg::*;
(
  input  pat_e       sel,
  input  logic [6:0] idx,
  output logic       bit_o
);
  always_comb begin
    case (sel)
      PAT_J2S:     bit_o = J2S_CODE[idx[3:0]];
      PAT_S2J:     bit_o = S2J_CODE[idx[3:0]];
      PAT_S2D:     bit_o = S2D_CODE[idx[3:0]];
      PAT_ALERT:   bit_o = ALERT_CODE[idx];
      PAT_ACT_SWD: bit_o = ACT_SWD[idx[2:0]];
      PAT_J2D:     bit_o = J2D_CODE[idx[4:0]];
      default:     bit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/dsg_seg_table.sv
module dsg_seg_table
  import modesw_pkg::*;
(
  input  logic [2:0]           cmd_sel,
  input  logic [SEG_IDX_W-1:0] seg_idx,
  input  logic [BIT_IDX_W-1:0] bit_idx,
  output seg_t                 seg,
  output logic                 seg_last,
  output logic                 bit_last
);
  always_comb begin
    seg      = seg_at(cmd_sel, seg_idx);
    bit_last = (bit_idx == seg.len - 8'd1);
    seg_last = (seg_idx == seg_count(cmd_sel) - 3'd1);
  end
endmodule

// File: rtl/modesw_gen.sv
module modesw_gen
  import modesw_pkg::*;
#(
  parameter int HALF_CYC = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [2:0] cmd,
  output logic       busy,
  output logic       done,
  output logic       lnk_clk,
  output logic       lnk_dat
);
  logic [2:0]           cmd_q;
  logic [SEG_IDX_W-1:0] seg_idx;
  logic [BIT_IDX_W-1:0] bit_idx;
  logic [CNT_W-1:0]     bit_cnt;
  logic                 phase_hi;

  // Named internal events
  logic accept, half_end, bit_tick, seg_end, seq_end;
  logic seg_last, bit_last, pat_bit, cur_bit;
  seg_t seg;

  assign accept   = start && !busy && cmd_ok(cmd);
  assign bit_tick = busy && half_end && phase_hi;
  assign seg_end  = bit_tick && bit_last;
  assign seq_end  = seg_end && seg_last;

  dsg_phase #(.HALF_CYC(HALF_CYC)) u_phase (
    .clk(clk), .rst_n(rst_n), .run(busy), .half_end(half_end)
  );

  dsg_seg_table u_tab (
    .cmd_sel(cmd_q), .seg_idx(seg_idx), .bit_idx(bit_idx),
    .seg(seg), .seg_last(seg_last), .bit_last(bit_last)
  );

  dsg_pattern u_pat (
    .sel(seg.pat), .idx(bit_idx[6:0]), .bit_o(pat_bit)
  );

  always_comb begin
    case (seg.kind)
      SEG_HIGH: cur_bit = 1'b1;
      SEG_PAT:  cur_bit = pat_bit;
      default:  cur_bit = 1'b0;
    endcase
  end

  assign lnk_clk = busy && phase_hi;
  assign lnk_dat = busy && cur_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      cmd_q    <= '0;
      seg_idx  <= '0;
      bit_idx  <= '0;
      bit_cnt  <= '0;
      phase_hi <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        busy     <= 1'b1;
        cmd_q    <= cmd;
        seg_idx  <= '0;
        bit_idx  <= '0;
        bit_cnt  <= '0;
        phase_hi <= 1'b0;
      end else if (busy && half_end) begin
        phase_hi <= !phase_hi;
        if (phase_hi) begin
          bit_cnt <= bit_cnt + 1'b1;
          if (seq_end) begin
            busy <= 1'b0;
            done <= 1'b1;
          end else if (seg_end) begin
            seg_idx <= seg_idx + 1'b1;
            bit_idx <= '0;
          end else begin
            bit_idx <= bit_idx + 1'b1;
          end
        end
      end
    end
  end

  // R9
  clk_hi_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lnk_clk && $past(lnk_clk)) |-> $stable(lnk_dat));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy ##1 !done));

  // R10
  busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R11
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (cmd_q == $past(cmd_q)));

  // R12
  bad_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && cmd == 3'd7) |=> !busy);

  // R2
  bit_total_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_end |-> (bit_cnt + 8'd1 == seq_bits(cmd_q)));
endmodule

// File: tb/modesw_gen_tb.sv
`timescale 1ns/1ps
module modesw_gen_tb;
  localparam int HALF = 2;

  logic clk = 0, rst_n = 0, start = 0;
  logic [2:0] cmd = '0;
  logic busy, done, lnk_clk, lnk_dat;

  int checks = 0, errors = 0;
  bit exp_q[$];
  string req = "R1";
  int popped = 0, rises = 0, cyc = 0, last_rise = 0;
  bit first_rise = 1, prev_clk = 0, held = 0;

  byte alert[16] = '{8'h92, 8'hF3, 8'h09, 8'h62, 8'h95, 8'h2D, 8'h85, 8'h86,
                     8'hE9, 8'hAF, 8'hDD, 8'hE3, 8'hA2, 8'h0E, 8'hBC, 8'h19};

  always #2 clk = ~clk;
  always @(posedge clk) cyc++;

  modesw_gen #(.HALF_CYC(HALF)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd(cmd),
    .busy(busy), .done(done), .lnk_clk(lnk_clk), .lnk_dat(lnk_dat));

  task automatic chk(bit ok, string r, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", r, what, act, exp);
    end
  endtask

  task automatic push_run(bit v, int n);
    for (int i = 0; i < n; i++) exp_q.push_back(v);
  endtask

  task automatic push_val(logic [31:0] v, int n);
    for (int i = 0; i < n; i++) exp_q.push_back(v[i]);
  endtask

  task automatic push_alert();
    for (int b = 0; b < 16; b++) push_val({24'h0, alert[b]}, 8);
  endtask

  // Monitor: samples on the rising link clock edge, seen at system negedge
  always @(negedge clk) begin
    if (rst_n) begin
      if (lnk_clk && !prev_clk) begin
        rises++;
        if (!first_rise)
          chk(cyc - last_rise == 2*HALF, "R9", "clock period", cyc - last_rise, 2*HALF);
        first_rise = 0;
        last_rise = cyc;
        held = lnk_dat;
        if (exp_q.size() == 0) chk(0, req, "extra bit", popped, 0);
        else begin
          bit e;
          e = exp_q.pop_front();
          chk(lnk_dat == e, req, $sformatf("bit %0d", popped), lnk_dat, e);
          popped++;
        end
      end else if (lnk_clk && prev_clk && lnk_dat != held) begin
        chk(0, "R9", "data moved while clock high", lnk_dat, held);
      end
    end
    prev_clk = lnk_clk;
  end

  task automatic run_seq(logic [2:0] c, string r, int poke_at);
    int n, w;
    req = r;
    case (c)
      3'd0: begin push_run(1, 56); push_run(0, 8); end
      3'd1: begin push_run(1, 56); push_val(32'hE79E, 16); push_run(1, 56); push_run(0, 8); end
      3'd2: begin push_run(1, 56); push_val(32'hE73C, 16); push_run(1, 8); end
      3'd3: begin push_run(1, 56); push_val(32'hE3BC, 16); end
      3'd4: begin push_run(1, 8); push_alert(); push_run(0, 4); push_val(32'h1A, 8);
                  push_run(1, 68); push_run(0, 8); end
      3'd5: begin push_run(1, 9); push_val(32'h33BBBBBA, 31); end
      default: begin push_run(1, 8); push_alert(); push_run(0, 24); end
    endcase
    n = exp_q.size();
    popped = 0;
    first_rise = 1;
    @(negedge clk); start = 1; cmd = c;
    @(negedge clk); start = 0; cmd = 3'd7;
    chk(busy == 1, "R10", "busy after start", busy, 1);
    w = 0;
    while (!done) begin
      @(negedge clk);
      w++;
      if (w == poke_at) begin start = 1; cmd = 3'd0; end
      if (w == poke_at + 1) begin
        start = 0;
        chk(busy == 1, "R11", "busy after ignored start", busy, 1);
      end
    end
    chk(busy == 0, "R10", "busy low with done", busy, 0);
    chk(popped == n, r, "bit count", popped, n);
    chk(exp_q.size() == 0, r, "bits left", exp_q.size(), 0);
    exp_q.delete();
    @(negedge clk);
    chk(done == 0, "R10", "done one cycle", done, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0 && lnk_clk == 0 && lnk_dat == 0, "R1", "reset outputs",
        {busy, done, lnk_clk, lnk_dat}, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk(busy == 0 && lnk_clk == 0 && lnk_dat == 0, "R1", "idle outputs",
        {busy, lnk_clk, lnk_dat}, 0);

    run_seq(3'd0, "R2", 0);
    run_seq(3'd1, "R3", 0);
    run_seq(3'd2, "R4", 0);
    run_seq(3'd3, "R5", 0);
    run_seq(3'd4, "R6", 300);
    run_seq(3'd5, "R7", 0);
    run_seq(3'd6, "R8", 41);

    begin
      int r0;
      r0 = rises;
      @(negedge clk); start = 1; cmd = 3'd7;
      @(negedge clk); start = 0;
      repeat (20) @(negedge clk);
      chk(busy == 0, "R12", "busy after code 7", busy, 0);
      chk(rises == r0, "R12", "clock pulses after code 7", rises - r0, 0);
    end

    run_seq(3'd0, "R2", 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule